// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Port

This block is the configuration port of a data converter. An external host talks to it over three wires: a serial clock, an active-low chip select and one bidirectional data line. The pad logic outside the block splits the data line into an input, an output and an output enable. The block oversamples all three pins in the core clock domain. It decodes a 16-bit instruction, then moves one or more data bytes to or from a byte-wide register map.

The register map has four kinds of entry:
- a port configuration byte, which holds the bit-order and soft-reset controls;
- a fixed identification byte;
- three program registers, which hold the clock stabilizer enable, the power-pin behaviour and the output coding;
- a commit register.

Writes to program registers only change a shadow copy. The block's control outputs follow only when the host sets the commit bit. This lets several settings change together.

Top module: `cfg_spi_slave`

## Requirements
- R1: After `rst_ni` is asserted, the registers hold their defaults: address 0x000 reads 0x18, 0x009 reads 0x01, 0x008 and 0x014 read 0x00. The outputs are `dcs_en_o`=1, `pdwn_standby_o`=0, `out_fmt_o`=00 and `sdio_oe_o`=0, and bit order is MSB-first.
- R2: Each frame starts with a 16-bit instruction, sampled on rising serial clock edges while chip select is low. Bit 15 is read (1) or write (0), bits 14:13 are the byte-count code and bits 12:0 are the start address.
- R3: Byte-count codes 00, 01 and 10 move exactly 1, 2 and 3 data bytes, and the block ignores further clocks until chip select rises. Code 11 moves bytes until chip select rises.
- R4: On a read, `sdio_oe_o` stays low during the instruction. It is high from just after the 16th rising edge until the last data byte is done, and each data bit is on `sdio_o` before the rising edge on which the host samples it.
- R5: Address 0x001 always reads the identification value 0x36, and writes to it have no effect.
- R6: Unimplemented addresses (for example 0x002 and 0x1FFF) read 0x00. The commit register 0x0FF also reads 0x00.
- R7: Writes to 0x008 (bit 0: 1 = standby, 0 = full power-down), 0x009 (bit 0: stabilizer enable) and 0x014 (bits 1:0: coding, 00 offset binary, 01 two's complement, 10 Gray) show at once on readback. The outputs change only when a write to 0x0FF has bit 0 set, and that bit then reads back as zero.
- R8: In a multi-byte transfer the address goes down by one per byte in MSB-first mode and up by one in LSB-first mode.
- R9: A write to 0x000 with bit 6 or bit 1 set selects LSB-first order for the instruction and data of later frames. The register then reads 0x5A.
- R10: A write to 0x000 with bit 5 or bit 2 set restores every default, including MSB-first order and the active outputs. The soft-reset bit reads back as zero.
- R11: Chip select going high at any point ends the frame. A partial byte is discarded, `sdio_oe_o` drops, and the next frame starts with a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| csb_i | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Data line, input side |
| sdio_o | output | 1 | Data line, output side (read data) |
| sdio_oe_o | output | 1 | Output enable for the data line pad |
| dcs_en_o | output | 1 | Active clock duty-cycle stabilizer enable |
| pdwn_standby_o | output | 1 | Active power-pin mode: 1 standby, 0 full power-down |
| out_fmt_o | output | 2 | Active output coding select |

## Verification
Assertions check these rules on every cycle:
- the output enable never coincides with a write strobe;
- the output enable falls after chip select rises;
- the output enable rises only at the end of an instruction;
- a finished frame stays quiet;
- the bit order changes only on a write to the port register;
- the active outputs change only on a commit or a soft reset.

Only the bench's scenarios can show the rest:
- the decoded values themselves;
- the direction of the address count in each bit order;
- the effect of each byte-count code;
- an extra byte being dropped;
- an aborted byte leaving a register untouched;
- the full restore after a soft reset.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ADDR_W  = 13;

  localparam logic [ADDR_W-1:0] A_PORTCFG = 13'h000;
  localparam logic [ADDR_W-1:0] A_CHIPID  = 13'h001;
  localparam logic [ADDR_W-1:0] A_PWR     = 13'h008;
  localparam logic [ADDR_W-1:0] A_DCS     = 13'h009;
  localparam logic [ADDR_W-1:0] A_FMT     = 13'h014;
  localparam logic [ADDR_W-1:0] A_XFER    = 13'h0FF;

  localparam logic [BYTE_W-1:0] D_PORTCFG = 8'h18;
  localparam logic [BYTE_W-1:0] D_PWR     = 8'h00;
  localparam logic [BYTE_W-1:0] D_DCS     = 8'h01;
  localparam logic [BYTE_W-1:0] D_FMT     = 8'h00;

  typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_e;

  typedef struct packed {
    logic [BYTE_W-1:0] pwr;
    logic [BYTE_W-1:0] dcs;
    logic [BYTE_W-1:0] fmt;
  } prog_t;

  localparam prog_t PROG_DEF = '{pwr: D_PWR, dcs: D_DCS, fmt: D_FMT};

  // active copy keeps only the bits that drive outputs
  typedef struct packed {
    logic       standby;
    logic       dcs_en;
    logic [1:0] fmt;
  } act_t;

  function automatic act_t to_act(prog_t p);
    to_act = '{standby: p.pwr[0], dcs_en: p.dcs[0], fmt: p.fmt[1:0]};
  endfunction
endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[s] <= RST_VAL;
        else         pipe_q[s] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[s] <= RST_VAL;
        else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame
  import cfg_spi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_act_i,
  input  logic              sdi_i,
  input  logic              lsb_first_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sdo_o,
  output logic              oe_o
);
  localparam int unsigned BIT_W = $clog2(INSTR_W);

  logic               sclk_d, sclk_rise;
  phase_e             phase_q;
  logic [BIT_W-1:0]   bit_q;
  logic [INSTR_W-1:0] ins_q, ins_nxt;
  logic               rw_q;
  logic [1:0]         wc_q, byte_q;
  logic [ADDR_W-1:0]  addr_q, addr_nxt;
  logic [BYTE_W-1:0]  rx_q, rx_nxt, tx_q;
  logic               oe_q, wr_en_q, last_byte;
  logic [ADDR_W-1:0]  wr_addr_q;
  logic [BYTE_W-1:0]  wr_data_q;

  assign sclk_rise = sclk_i & ~sclk_d;
  assign ins_nxt   = lsb_first_i ? {sdi_i, ins_q[INSTR_W-1:1]} : {ins_q[INSTR_W-2:0], sdi_i};
  assign rx_nxt    = lsb_first_i ? {sdi_i, rx_q[BYTE_W-1:1]} : {rx_q[BYTE_W-2:0], sdi_i};
  assign addr_nxt  = lsb_first_i ? addr_q + 1'b1 : addr_q - 1'b1;
  assign last_byte = (wc_q != 2'b11) && (byte_q == wc_q);
  assign rd_addr_o = (phase_q == PH_INSTR) ? ins_nxt[ADDR_W-1:0] : addr_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d    <= 1'b0;
      phase_q   <= PH_INSTR;
      bit_q     <= '0;
      ins_q     <= '0;
      rw_q      <= 1'b0;
      wc_q      <= '0;
      byte_q    <= '0;
      addr_q    <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      oe_q      <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      sclk_d  <= sclk_i;
      wr_en_q <= 1'b0;
      if (!cs_act_i) begin
        phase_q <= PH_INSTR;
        bit_q   <= '0;
        oe_q    <= 1'b0;
      end else if (sclk_rise) begin
        case (phase_q)
          PH_INSTR: begin
            ins_q <= ins_nxt;
            bit_q <= bit_q + 1'b1;
            if (bit_q == BIT_W'(INSTR_W-1)) begin
              rw_q    <= ins_nxt[INSTR_W-1];
              wc_q    <= ins_nxt[INSTR_W-2 -: 2];
              addr_q  <= ins_nxt[ADDR_W-1:0];
              byte_q  <= '0;
              bit_q   <= '0;
              phase_q <= PH_DATA;
              if (ins_nxt[INSTR_W-1]) begin
                tx_q <= rd_data_i;
                oe_q <= 1'b1;
              end
            end
          end
          PH_DATA: begin
            rx_q  <= rx_nxt;
            tx_q  <= lsb_first_i ? (tx_q >> 1) : (tx_q << 1);
            bit_q <= bit_q + 1'b1;
            if (bit_q == BIT_W'(BYTE_W-1)) begin
              bit_q  <= '0;
              byte_q <= byte_q + 1'b1;
              addr_q <= addr_nxt;
              if (!rw_q) begin
                wr_en_q   <= 1'b1;
                wr_addr_q <= addr_q;
                wr_data_q <= rx_nxt;
              end
              if (last_byte) begin
                phase_q <= PH_DONE;
                oe_q    <= 1'b0;
              end else if (rw_q) begin
                tx_q <= rd_data_i;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdo_o     = lsb_first_i ? tx_q[0] : tx_q[BYTE_W-1];
  assign oe_o      = oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;

  // R4
  oe_vs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !oe_o);
  // R11
  abort_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !oe_o);
  // R4
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(phase_q) == PH_INSTR);
  // R3
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DONE && $past(phase_q) == PH_DONE) |-> (!wr_en_o && !oe_o));
endmodule

// File: rtl/cfg_spi_regs.sv
module cfg_spi_regs
  import cfg_spi_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CHIP_ID = 8'h36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              lsb_first_o,
  output logic              dcs_en_o,
  output logic              standby_o,
  output logic [1:0]        fmt_o
);
  logic  lsb_q;
  prog_t sh_q;
  act_t  act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsb_q <= 1'b0;
      sh_q  <= PROG_DEF;
      act_q <= to_act(PROG_DEF);
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_PORTCFG: begin
          // mirrored nibbles: either copy of a control bit counts
          if (wr_data_i[5] | wr_data_i[2]) begin
            lsb_q <= 1'b0;
            sh_q  <= PROG_DEF;
            act_q <= to_act(PROG_DEF);
          end else begin
            lsb_q <= wr_data_i[6] | wr_data_i[1];
          end
        end
        A_PWR:  sh_q.pwr <= wr_data_i;
        A_DCS:  sh_q.dcs <= wr_data_i;
        A_FMT:  sh_q.fmt <= wr_data_i;
        A_XFER: if (wr_data_i[0]) act_q <= to_act(sh_q);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr_i)
      A_PORTCFG: rd_data_o = D_PORTCFG | {1'b0, lsb_q, 4'b0000, lsb_q, 1'b0};
      A_CHIPID:  rd_data_o = CHIP_ID;
      A_PWR:     rd_data_o = sh_q.pwr;
      A_DCS:     rd_data_o = sh_q.dcs;
      A_FMT:     rd_data_o = sh_q.fmt;
      default:   rd_data_o = '0;
    endcase
  end

  assign lsb_first_o = lsb_q;
  assign dcs_en_o    = act_q.dcs_en;
  assign standby_o   = act_q.standby;
  assign fmt_o       = act_q.fmt;

  // R9
  order_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lsb_q) |-> $past(wr_en_i && wr_addr_i == A_PORTCFG));
  // R7
  commit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(wr_en_i && (wr_addr_i == A_XFER || wr_addr_i == A_PORTCFG)));
endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave
  import cfg_spi_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] CHIP_ID     = 8'h36
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       csb_i,
  input  logic       sdio_i,
  output logic       sdio_o,
  output logic       sdio_oe_o,
  output logic       dcs_en_o,
  output logic       pdwn_standby_o,
  output logic [1:0] out_fmt_o
);
  logic [2:0]        pins_s;
  logic              lsb_first;
  logic [BYTE_W-1:0] rd_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data;

  cfg_spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, csb_i, sdio_i}),
    .q_o    (pins_s)
  );

  cfg_spi_frame u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (pins_s[2]),
    .cs_act_i    (~pins_s[1]),
    .sdi_i       (pins_s[0]),
    .lsb_first_i (lsb_first),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .sdo_o       (sdio_o),
    .oe_o        (sdio_oe_o)
  );

  cfg_spi_regs #(.CHIP_ID(CHIP_ID)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .lsb_first_o (lsb_first),
    .dcs_en_o    (dcs_en_o),
    .standby_o   (pdwn_standby_o),
    .fmt_o       (out_fmt_o)
  );
endmodule

// File: tb/cfg_spi_slave_bench.sv
module cfg_spi_slave_bench;
  localparam int HALF = 8;
  localparam int NVEC = 10;
  // {req[3:0], wr, addr[12:0], wdata, expected}
  localparam logic [33:0] VEC [NVEC] = '{
    {4'd1, 1'b0, 13'h000, 8'h00, 8'h18},  // R1 port config default
    {4'd5, 1'b0, 13'h001, 8'h00, 8'h36},  // R5 id
    {4'd5, 1'b1, 13'h001, 8'hAA, 8'h00},  // R5 write ignored
    {4'd5, 1'b0, 13'h001, 8'h00, 8'h36},  // R5
    {4'd6, 1'b0, 13'h002, 8'h00, 8'h00},  // R6 unimplemented
    {4'd6, 1'b0, 13'h1FFF, 8'h00, 8'h00}, // R6
    {4'd1, 1'b0, 13'h009, 8'h00, 8'h01},  // R1 dcs default
    {4'd7, 1'b1, 13'h014, 8'h02, 8'h00},  // R7 shadow write
    {4'd7, 1'b0, 13'h014, 8'h00, 8'h02},  // R7 readback
    {4'd6, 1'b0, 13'h0FF, 8'h00, 8'h00}   // R6 commit reads zero
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csb = 1'b1, sdi = 1'b0;
  logic sdo, oe, dcs_en, standby;
  logic [1:0] fmt;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] tx_buf [4];
  logic [7:0] rx_buf [4];
  logic oe_mid, oe_data;

  always #2.5 clk = ~clk;

  cfg_spi_slave u_cfg_spi_slave (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csb_i(csb), .sdio_i(sdi),
    .sdio_o(sdo), .sdio_oe_o(oe), .dcs_en_o(dcs_en), .pdwn_standby_o(standby),
    .out_fmt_o(fmt)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, output logic r);
    sclk = 1'b0;
    sdi  = b;
    repeat (HALF) @(negedge clk);
    r = sdo;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame(input logic rd, input logic [1:0] wc, input logic [12:0] a,
                       input int nb, input logic lsb);
    logic [15:0] ins;
    logic r;
    ins = {rd, wc, a};
    csb = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      send_bit(lsb ? ins[i] : ins[15-i], r);
      if (i == 8) oe_mid = oe;
    end
    for (int k = 0; k < nb; k++) begin
      rx_buf[k] = '0;
      for (int j = 0; j < 8; j++) begin
        send_bit(lsb ? tx_buf[k][j] : tx_buf[k][7-j], r);
        if (k == 0 && j == 0) oe_data = oe;
        rx_buf[k] = lsb ? {r, rx_buf[k][7:1]} : {rx_buf[k][6:0], r};
      end
    end
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    csb = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] d, input logic lsb);
    tx_buf[0] = d;
    frame(1'b0, 2'b00, a, 1, lsb);
  endtask

  task automatic rd1(input logic [12:0] a, input logic lsb, output logic [7:0] d);
    tx_buf[0] = '0;
    frame(1'b1, 2'b00, a, 1, lsb);
    d = rx_buf[0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 oe", {7'd0, oe}, 8'h00);
    chk("R1 dcs_en", {7'd0, dcs_en}, 8'h01);
    chk("R1 standby", {7'd0, standby}, 8'h00);
    chk("R1 fmt", {6'd0, fmt}, 8'h00);

    // R2 single-byte frames driven from the table
    for (int n = 0; n < NVEC; n++) begin
      if (VEC[n][29]) wr1(VEC[n][28:16], VEC[n][15:8], 1'b0);
      else begin
        rd1(VEC[n][28:16], 1'b0, v);
        total++;
        if (v !== VEC[n][7:0]) begin
          bad++;
          $display("FAIL R%0d vec %0d act=%h exp=%h", VEC[n][33:30], n, v, VEC[n][7:0]);
        end
      end
    end

    // R4 direction of the data line on the last table read
    chk("R4 oe during instr", {7'd0, oe_mid}, 8'h00);
    chk("R4 oe during data", {7'd0, oe_data}, 8'h01);
    chk("R4 oe after frame", {7'd0, oe}, 8'h00);

    // R7 shadow vs active
    chk("R7 fmt before commit", {6'd0, fmt}, 8'h00);
    wr1(13'h009, 8'h00, 1'b0);
    wr1(13'h008, 8'h01, 1'b0);
    chk("R7 dcs before commit", {7'd0, dcs_en}, 8'h01);
    chk("R7 standby before commit", {7'd0, standby}, 8'h00);
    wr1(13'h0FF, 8'h01, 1'b0);
    chk("R7 dcs after commit", {7'd0, dcs_en}, 8'h00);
    chk("R7 standby after commit", {7'd0, standby}, 8'h01);
    chk("R7 fmt after commit", {6'd0, fmt}, 8'h02);
    rd1(13'h0FF, 1'b0, v);
    chk("R7 commit self-clear", v, 8'h00);

    // R3 R8 three-byte write, addresses descend
    tx_buf[0] = 8'h01; tx_buf[1] = 8'h00; tx_buf[2] = 8'h77;
    frame(1'b0, 2'b10, 13'h009, 3, 1'b0);
    tx_buf[0] = '0; tx_buf[1] = '0;
    frame(1'b1, 2'b01, 13'h009, 2, 1'b0);
    chk("R8 msb byte0", rx_buf[0], 8'h01);
    chk("R8 msb byte1", rx_buf[1], 8'h00);

    // R3 streaming write and read
    tx_buf[0] = 8'h03; tx_buf[1] = 8'h01;
    frame(1'b0, 2'b11, 13'h009, 2, 1'b0);
    tx_buf[0] = '0; tx_buf[1] = '0; tx_buf[2] = '0;
    frame(1'b1, 2'b11, 13'h009, 3, 1'b0);
    chk("R3 stream b0", rx_buf[0], 8'h03);
    chk("R3 stream b1", rx_buf[1], 8'h01);
    chk("R3 stream b2", rx_buf[2], 8'h00);

    // R3 extra byte after a one-byte write is ignored
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h05;
    frame(1'b0, 2'b00, 13'h009, 2, 1'b0);
    rd1(13'h008, 1'b0, v);
    chk("R3 extra byte ignored", v, 8'h01);
    rd1(13'h009, 1'b0, v);
    chk("R3 first byte written", v, 8'h00);

    // R11 abort mid write byte
    csb = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 16; i++) send_bit(i == 15 || i == 12, r); // write 0x009 code 00
    for (int i = 0; i < 4; i++) send_bit(1'b1, r);
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    csb = 1'b1;
    repeat (10) @(negedge clk);
    rd1(13'h009, 1'b0, v);
    chk("R11 partial byte dropped", v, 8'h00);

    // R11 abort mid read drops oe
    csb = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 16; i++) send_bit(i == 0 || i == 15, r); // read 0x001
    for (int i = 0; i < 3; i++) send_bit(1'b0, r);
    chk("R4 oe mid read", {7'd0, oe}, 8'h01);
    csb = 1'b1;
    repeat (8) @(negedge clk);
    chk("R11 oe after abort", {7'd0, oe}, 8'h00);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    rd1(13'h001, 1'b0, v);
    chk("R11 fresh frame", v, 8'h36);

    // R9 LSB-first
    wr1(13'h000, 8'h42, 1'b0);
    rd1(13'h000, 1'b1, v);
    chk("R9 port cfg", v, 8'h5A);
    tx_buf[0] = 8'h07; tx_buf[1] = 8'h02;
    frame(1'b0, 2'b01, 13'h008, 2, 1'b1);
    tx_buf[0] = '0; tx_buf[1] = '0;
    frame(1'b1, 2'b01, 13'h008, 2, 1'b1);
    chk("R8 lsb byte0", rx_buf[0], 8'h07);
    chk("R8 lsb byte1", rx_buf[1], 8'h02);

    // R10 soft reset issued in LSB-first order
    wr1(13'h000, 8'h24, 1'b1);
    rd1(13'h000, 1'b0, v);
    chk("R10 port cfg", v, 8'h18);
    rd1(13'h009, 1'b0, v);
    chk("R10 dcs shadow", v, 8'h01);
    rd1(13'h008, 1'b0, v);
    chk("R10 pwr shadow", v, 8'h00);
    chk("R10 dcs_en", {7'd0, dcs_en}, 8'h01);
    chk("R10 standby", {7'd0, standby}, 8'h00);
    chk("R10 fmt", {6'd0, fmt}, 8'h00);

    // R1 reset pin restores order
    wr1(13'h000, 8'h42, 1'b0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rd1(13'h000, 1'b0, v);
    chk("R1 after reset pin", v, 8'h18);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule